// File: doc/BRIEF.md
# Edge-Clocked Serial Word Transmitter

This block sends a data word on one output line. It advances one bit for each active edge of a clock that arrives on an input from outside the block, and it sends the least-significant bit first. The block does not make its own serial clock. It only watches the incoming clock line. That line passes through a two-flop synchronizer and an edge detector, all running on the system clock. Three configuration inputs set the behaviour:

- the word length, given as length minus one;
- a single-word mode, in which the line falls to idle low after the word, or a streaming mode, in which the remaining register bits keep going out;
- an inversion bit, which makes the falling edge of the clock active instead of the rising edge.

A write strobe loads the word, and its bit 0 appears on the line at once. The bit counter runs freely on every active edge while the block is enabled. A write does not reset the counter. An edge that arrives before the intended word is loaded therefore leaves every later word out of alignment, and only lowering the enable cures it. When a word boundary is reached after a write, a done flag is raised. The flag stays high until the next write. Holding the enable low keeps the block in reset with its line low.

Top module: `sync_serial_tx`

## Requirements
- R1: While `enable` is low, `tx_out` and `word_done` are 0, and clock edges and write strobes have no effect on either output.
- R2: A write strobe with `enable` high loads `wr_data`, and its bit 0 is on `tx_out` one system clock later.
- R3: Each active serial clock edge shifts the word right by one bit, least-significant bit first. The new bit appears on `tx_out` three system clocks after the input transition: two synchronizer stages plus the register stage.
- R4: With `cfg_clk_inv` = 0 only rising transitions of `sclk_in` are active. With `cfg_clk_inv` = 1 only falling transitions are active. A transition in the other direction leaves `tx_out` unchanged.
- R5: A word boundary occurs on the active edge at which the free-running bit count equals `cfg_len_m1`. The count then returns to 0, so a word spans `cfg_len_m1`+1 edges.
- R6: With `cfg_single` = 1, the boundary edge drives `tx_out` to 0, and it stays 0 on later edges until the next write.
- R7: With `cfg_single` = 0, shifting continues past the boundary, so register bits above the word length keep going out.
- R8: `word_done` rises at a boundary that follows a write. It holds through later edges and returns to 0 one clock after the next write strobe.
- R9: Active edges advance the bit count whether or not a word is loaded, and a write does not reset the count. After one stray edge, an 8-bit word reaches its boundary after 7 edges.
- R10: Raising `enable` while `sclk_in` sits at the active-edge level produces no edge, because the synchronizer keeps tracking the pin while the block is disabled.
- R11: Writing a zero word returns `tx_out` to 0 one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Arms the block when high; holds it in reset when low |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_single | input | 1 | 1 = single-word mode, 0 = streaming mode |
| cfg_clk_inv | input | 1 | 1 = falling edge of `sclk_in` is active |
| sclk_in | input | 1 | External serial clock, asynchronous to `clk` |
| wr_stb | input | 1 | Single-cycle strobe that loads `wr_data` |
| wr_data | input | 32 | Word to send, least-significant bit first |
| tx_out | output | 1 | Serial data line |
| word_done | output | 1 | High after a loaded word reaches its boundary |

## Verification
A write is visible on `tx_out` and `word_done` one system clock after the strobe. A serial clock transition reaches them on the third system clock. The bench drives the serial clock in phases of four system clocks, so each directed check falls after that latency has passed and before the next transition.

A behavioural reference model takes in the same inputs at each rising clock edge. It delays the serial clock samples through a short queue to give the same three-cycle latency, and it is compared with both outputs on every falling edge.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W  = $clog2(DATA_W);

  typedef struct packed {
    logic             single;
    logic             clk_inv;
    logic [LEN_W-1:0] len_m1;
  } sst_cfg_t;
endpackage

// File: rtl/sst_edge_detect.sv
module sst_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic invert,
  output logic act_edge
);
  localparam int unsigned HIST = STAGES + 1;

  logic [HIST-1:0] hist_q, hist_d;
  logic            lvl_now, lvl_old;

  always_comb hist_d = {hist_q[HIST-2:0], sclk_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_comb begin
    lvl_now  = hist_q[STAGES-1] ^ invert;
    lvl_old  = hist_q[STAGES]   ^ invert;
    act_edge = lvl_now & ~lvl_old;
  end

  // an active edge is a single-cycle pulse
  assert_edge_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_edge && $stable(invert)) |=> !act_edge);
endmodule

// File: rtl/sst_bit_counter.sv
module sst_bit_counter #(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic [LEN_W-1:0] len_m1,
  output logic             boundary
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    boundary = step && (cnt_q >= len_m1);
    cnt_ce   = !en || step;
    cnt_d    = cnt_q;
    if (!en)           cnt_d = '0;
    else if (boundary) cnt_d = '0;
    else if (step)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assert_count_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && !boundary) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_count_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && boundary) |=> (cnt_q == '0));
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              step,
  input  logic              boundary,
  input  logic              single,
  output logic              bit_out
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sh_ce;

  always_comb begin
    sh_ce = !en || load || step;
    sh_d  = sh_q;
    if (!en)                       sh_d = '0;
    else if (load)                 sh_d = load_data;
    else if (step && boundary && single) sh_d = '0;
    else if (step)                 sh_d = {1'b0, sh_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_ce) sh_q <= sh_d;
  end

  assign bit_out = sh_q[0];

  assert_shift_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && !load && !(boundary && single)) |=> (sh_q == ($past(sh_q) >> 1)));
  assert_single_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && boundary && single && !load) |=> (sh_q == '0));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> (bit_out == $past(load_data[0])));
endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
  import sst_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [LW-1:0] cfg_len_m1,
  input  logic          cfg_single,
  input  logic          cfg_clk_inv,
  input  logic          sclk_in,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          tx_out,
  output logic          word_done
);
  logic act_edge, step, boundary, load;
  logic loaded_q, loaded_d, done_q, done_d, flag_ce;

  sst_edge_detect #(.STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in),
    .invert(cfg_clk_inv), .act_edge(act_edge)
  );

  always_comb begin
    step = enable && act_edge;
    load = enable && wr_stb;
  end

  sst_bit_counter #(.LEN_W(LW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(enable), .step(step),
    .len_m1(cfg_len_m1), .boundary(boundary)
  );

  sst_shifter #(.DATA_W(DW)) u_sh (
    .clk(clk), .rst_n(rst_n), .en(enable), .load(load),
    .load_data(wr_data), .step(step), .boundary(boundary),
    .single(cfg_single), .bit_out(tx_out)
  );

  always_comb begin
    flag_ce  = !enable || load || boundary;
    loaded_d = loaded_q;
    done_d   = done_q;
    if (!enable) begin
      loaded_d = 1'b0;
      done_d   = 1'b0;
    end else if (load) begin
      loaded_d = 1'b1;
      done_d   = 1'b0;
    end else if (boundary) begin
      loaded_d = 1'b0;
      done_d   = done_q | loaded_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (flag_ce) begin
      loaded_q <= loaded_d;
      done_q   <= done_d;
    end
  end

  assign word_done = done_q;

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!tx_out && !word_done));
  assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_stb) |=> !word_done);
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && word_done && !wr_stb) |=> word_done);
endmodule

// File: tb/tb_sync_serial_tx.sv
module tb_sync_serial_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_PH    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [4:0]  cfg_len_m1 = 5'd7;
  logic        cfg_single = 1'b1;
  logic        cfg_clk_inv = 1'b0;
  logic        sclk_in = 1'b0;
  logic        wr_stb = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tx_out, word_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_tx dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_len_m1(cfg_len_m1),
    .cfg_single(cfg_single), .cfg_clk_inv(cfg_clk_inv), .sclk_in(sclk_in),
    .wr_stb(wr_stb), .wr_data(wr_data), .tx_out(tx_out), .word_done(word_done)
  );

  // reference model
  logic        q[$] = '{1'b0, 1'b0, 1'b0};
  logic [31:0] m_sh = '0;
  int          m_cnt = 0;
  bit          m_loaded = 0, m_done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q = '{1'b0, 1'b0, 1'b0};
      m_sh = '0; m_cnt = 0; m_loaded = 0; m_done = 0;
    end else begin
      bit e, bnd;
      e = (q[q.size()-2] ^ cfg_clk_inv) && !(q[q.size()-3] ^ cfg_clk_inv);
      q.push_back(sclk_in);
      void'(q.pop_front());
      if (!enable) begin
        m_sh = '0; m_cnt = 0; m_loaded = 0; m_done = 0;
      end else begin
        bnd = e && (m_cnt >= int'(cfg_len_m1));
        if (e) m_cnt = bnd ? 0 : m_cnt + 1;
        if (wr_stb) begin
          m_sh = wr_data; m_loaded = 1; m_done = 0;
        end else if (e) begin
          m_sh = (bnd && cfg_single) ? 32'd0 : (m_sh >> 1);
          if (bnd) begin
            if (m_loaded) m_done = 1;
            m_loaded = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (tx_out !== m_sh[0] || word_done !== m_done) begin
        errors++;
        $display("FAIL R3 model compare: tx/done actual %b%b expected %b%b",
                 tx_out, word_done, m_sh[0], m_done);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic set_sclk(input logic v);
    @(negedge clk); sclk_in = v;
    repeat (HALF_PH-1) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      set_sclk(~sclk_in);
      set_sclk(~sclk_in);
    end
  endtask

  task automatic rearm;
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    chk("R1 reset tx", tx_out, 0);
    chk("R1 reset done", word_done, 0);
    rst_n = 1'b1;
    // disabled: edges and writes ignored
    wr(32'hFFFF_FFFF);
    pulse(2);
    chk("R1 disabled tx", tx_out, 0);
    chk("R1 disabled done", word_done, 0);
    // 8-bit single-word, rising edge
    rearm();
    w = 32'hA5;
    wr(w);
    chk("R2 bit0 after load", tx_out, w[0]);
    for (int i = 1; i < 8; i++) begin
      pulse(1);
      chk("R3 lsb-first bit", tx_out, w[i]);
    end
    chk("R5 not done before boundary", word_done, 0);
    pulse(1);
    chk("R5 done at 8th edge", word_done, 1);
    chk("R6 idle low after word", tx_out, 0);
    pulse(3);
    chk("R6 stays low", tx_out, 0);
    chk("R8 done held", word_done, 1);
    wr(32'h3);
    chk("R8 done cleared by write", word_done, 0);
    chk("R2 new word bit0", tx_out, 1);
    // falling edge selection
    @(negedge clk); enable = 1'b0; cfg_clk_inv = 1'b1;
    @(negedge clk); enable = 1'b1;
    wr(32'h1);
    set_sclk(1'b1);
    chk("R4 rising ignored when inverted", tx_out, 1);
    set_sclk(1'b0);
    chk("R4 falling active when inverted", tx_out, 0);
    // streaming mode, 4-bit words
    @(negedge clk); enable = 1'b0; cfg_clk_inv = 1'b0; cfg_single = 1'b0; cfg_len_m1 = 5'd3;
    @(negedge clk); enable = 1'b1;
    w = 32'h35;
    wr(w);
    pulse(4);
    chk("R5 done after 4-bit word", word_done, 1);
    chk("R7 stream bit4", tx_out, w[4]);
    pulse(1);
    chk("R7 stream bit5", tx_out, w[5]);
    pulse(1);
    chk("R7 stream bit6", tx_out, w[6]);
    // stray edge misalignment
    @(negedge clk); enable = 1'b0; cfg_single = 1'b1; cfg_len_m1 = 5'd7;
    @(negedge clk); enable = 1'b1;
    pulse(1);
    wr(32'hFF);
    pulse(7);
    chk("R9 early boundary done", word_done, 1);
    chk("R9 truncated word idle", tx_out, 0);
    // enable while clock high gives no edge
    @(negedge clk); enable = 1'b0;
    set_sclk(1'b1);
    @(negedge clk); enable = 1'b1;
    wr(32'h1);
    repeat (HALF_PH) @(negedge clk);
    chk("R10 no edge on enable", tx_out, 1);
    // zero write returns line low
    wr(32'h0);
    chk("R11 zero write idle", tx_out, 0);
    set_sclk(1'b0);
    finish_run();
  end
endmodule